// File: doc/BRIEF.md
# Decoded Parallel Output Port

This block is a write-only parallel output port for an 8-bit-data processor bus. It watches the address bus, the data bus and the active-low bus strobes. When a write cycle is aimed at its own device address, it keeps the data byte in an output register. That register drives LEDs, relays or similar loads, and it keeps its value until the next accepted write. A one-clock pulse marks each byte that is taken.

A parameter chooses how the address is decoded.
- **Port decode:** only the low 8 address bits are compared, so the port space runs from 00h to FFh. The access must be qualified by the I/O request strobe.
- **Memory decode:** all 16 address bits are compared, and the access must be qualified by the memory request strobe.

Both decodes also need the write strobe to be low.

The bus is sampled on the system clock. The byte is taken when the qualified select window closes, which is the trailing edge of the strobes. The value kept is the one present on the data bus in the last sampled cycle of the window.

Top module: `outport_latch`

## Requirements
- R1: While reset is asserted, and after it is released with no write yet, `port_q` is 00h and `wr_pulse` is 0.
- R2: With `MODE` = port decode, a write is accepted when all three of these hold in the same sampled cycle: `iorq_n` is 0, `wr_n` is 0, and `addr[7:0]` equals the low 8 bits of `PORT_ADDR`. Address bits 15:8 play no part in this decode.
- R3: With `MODE` = memory decode, a write is accepted when all three of these hold in the same sampled cycle: `mreq_n` is 0, `wr_n` is 0, and all 16 bits of `addr` equal `PORT_ADDR`.
- R4: A request strobe of the other bus type does not touch `port_q` or `wr_pulse`. In port decode that is `mreq_n`; in memory decode it is `iorq_n`.
- R5: A read cycle, where the request strobe is low but `wr_n` is 1, leaves `port_q` unchanged and gives no pulse.
- R6: An access whose compared address bits differ from `PORT_ADDR` leaves `port_q` unchanged and gives no pulse.
- R7: `port_q` stays the same while the select window is open. It takes the byte from the last in-window sampled cycle on the second rising clock edge after the strobes are seen inactive, so the bus value three cycles back appears at the output.
- R8: `wr_pulse` is high for exactly one clock per accepted write, however long the window lasts. It rises in the same cycle that `port_q` is updated.
- R9: `port_q` changes only in a cycle where `wr_pulse` is high, and it holds its value between writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Processor address bus |
| data | input | DATA_W | Processor data bus |
| iorq_n | input | 1 | I/O request strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| port_q | output | DATA_W | Latched output byte |
| wr_pulse | output | 1 | One-clock pulse for each accepted write |

## Verification
The bench builds two copies of the block on one shared bus:
- one in port decode at address 07h;
- one in memory decode at 8007h.

Every bus cycle therefore tests both decodes side by side. An I/O write to 8007h hits the port copy through its low byte. The same write misses the memory copy, because the strobe type is wrong.

This pairing brings within reach several cases that a single build cannot show at once:
- the upper address bits being ignored in port decode;
- the full 16-bit compare in memory decode;
- the effect of each strobe type on each decode.

Directed cases then cover a data change inside a long window, a window held for many cycles, and a reset after a write.

// File: rtl/outport_pkg.sv
package outport_pkg;

   // Address decode variant selected by the MODE parameter.
   typedef enum logic {
      DEC_PORT = 1'b0,   // low byte compare, qualified by I/O request
      DEC_MEM  = 1'b1    // full address compare, qualified by memory request
   } dec_mode_e;

   // Width of the compare used in port decode.
   localparam int unsigned PORT_SPACE_W = 8;

   // Number of address bits a decode variant compares.
   function automatic int unsigned match_width(dec_mode_e m, int unsigned addr_w);
      return (m == DEC_PORT) ? PORT_SPACE_W : addr_w;
   endfunction

endpackage

// File: rtl/outport_sampler.sv
// Registers the bus once on the system clock so that all decode and
// capture logic works on values from a single sampling instant.
module outport_sampler #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              iorq_n,
   input  logic              mreq_n,
   input  logic              wr_n,
   output logic [ADDR_W-1:0] s_addr,
   output logic [DATA_W-1:0] s_data,
   output logic              s_iorq,
   output logic              s_mreq,
   output logic              s_wr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_addr <= '0;
         s_data <= '0;
         s_iorq <= 1'b0;
         s_mreq <= 1'b0;
         s_wr   <= 1'b0;
      end else begin
         s_addr <= addr;
         s_data <= data;
         s_iorq <= ~iorq_n;
         s_mreq <= ~mreq_n;
         s_wr   <= ~wr_n;
      end
   end

endmodule

// File: rtl/outport_decode.sv
// Address match qualified by the bus-type strobe and the write strobe.
module outport_decode
   import outport_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter dec_mode_e   MODE      = DEC_PORT,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0007
) (
   input  logic [ADDR_W-1:0] s_addr,
   input  logic              s_iorq,
   input  logic              s_mreq,
   input  logic              s_wr,
   output logic              sel
);

   localparam int unsigned MATCH_W = match_width(MODE, ADDR_W);

   logic addr_hit;
   logic req_hit;

   generate
      if (MODE == DEC_PORT) begin : g_port
         localparam logic [MATCH_W-1:0] KEY = PORT_ADDR[MATCH_W-1:0];
         logic [ADDR_W-MATCH_W-1:0] unused_hi;
         assign unused_hi = s_addr[ADDR_W-1:MATCH_W];
         assign addr_hit  = (s_addr[MATCH_W-1:0] == KEY);
         assign req_hit   = s_iorq;
      end else begin : g_mem
         assign addr_hit = (s_addr == PORT_ADDR);
         assign req_hit  = s_mreq;
      end
   endgenerate

   assign sel = addr_hit & req_hit & s_wr;

endmodule

// File: rtl/outport_capture.sv
// Holds the last in-window byte and commits it when the select window closes.
module outport_capture #(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [DATA_W-1:0] s_data,
   output logic [DATA_W-1:0] port_q,
   output logic              wr_pulse
);

   logic              sel_d;
   logic [DATA_W-1:0] hold_q;
   logic              close_evt;

   assign close_evt = sel_d & ~sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_d  <= 1'b0;
         hold_q <= RESET_VAL;
      end else begin
         sel_d <= sel;
         if (sel) hold_q <= s_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q   <= RESET_VAL;
         wr_pulse <= 1'b0;
      end else begin
         wr_pulse <= close_evt;
         if (close_evt) port_q <= hold_q;
      end
   end

endmodule

// File: rtl/outport_latch.sv
// Decoded parallel output port: sample, decode, capture on trailing edge.
module outport_latch
   import outport_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter dec_mode_e   MODE      = DEC_PORT,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0007
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              iorq_n,
   input  logic              mreq_n,
   input  logic              wr_n,
   output logic [DATA_W-1:0] port_q,
   output logic              wr_pulse
);

   generate
      if (ADDR_W < PORT_SPACE_W) begin : g_bad_addr_w
         $error("outport_latch: ADDR_W must be at least the port space width");
      end
      if (DATA_W == 0) begin : g_bad_data_w
         $error("outport_latch: DATA_W must be nonzero");
      end
   endgenerate

   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_data;
   logic              s_iorq;
   logic              s_mreq;
   logic              s_wr;
   logic              sel;

   outport_sampler #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_sampler (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (addr),
      .data   (data),
      .iorq_n (iorq_n),
      .mreq_n (mreq_n),
      .wr_n   (wr_n),
      .s_addr (s_addr),
      .s_data (s_data),
      .s_iorq (s_iorq),
      .s_mreq (s_mreq),
      .s_wr   (s_wr)
   );

   outport_decode #(
      .ADDR_W    (ADDR_W),
      .MODE      (MODE),
      .PORT_ADDR (PORT_ADDR)
   ) u_decode (
      .s_addr (s_addr),
      .s_iorq (s_iorq),
      .s_mreq (s_mreq),
      .s_wr   (s_wr),
      .sel    (sel)
   );

   outport_capture #(
      .DATA_W    (DATA_W),
      .RESET_VAL ('0)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .s_data   (s_data),
      .port_q   (port_q),
      .wr_pulse (wr_pulse)
   );

endmodule

// File: rtl/outport_latch_chk.sv
module outport_latch_chk
   import outport_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter dec_mode_e   MODE      = DEC_PORT,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0007
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] data,
   input logic              iorq_n,
   input logic              mreq_n,
   input logic              wr_n,
   input logic [DATA_W-1:0] port_q,
   input logic              wr_pulse
);

   localparam int unsigned MATCH_W = match_width(MODE, ADDR_W);
   localparam logic [ADDR_W-1:0] MASK = (MATCH_W >= ADDR_W) ? '1 :
                                        ADDR_W'((64'd1 << MATCH_W) - 64'd1);

   logic own_req;
   logic bus_hit;
   assign own_req = (MODE == DEC_PORT) ? ~iorq_n : ~mreq_n;
   assign bus_hit = own_req & ~wr_n & ((addr & MASK) == (PORT_ADDR & MASK));

   // R8
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);

   // R9
   out_only_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_q != $past(port_q)) |-> wr_pulse);

   // R2
   hit_before_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> $past(bus_hit, 3));

   // R7
   trailing_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> !$past(bus_hit, 2));

   // R7
   byte_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> (port_q == $past(data, 3)));

   // R5
   no_read_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> !$past(wr_n, 3));

   // R4
   strobe_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> $past(own_req, 3));

endmodule

bind outport_latch outport_latch_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .MODE      (MODE),
   .PORT_ADDR (PORT_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .data     (data),
   .iorq_n   (iorq_n),
   .mreq_n   (mreq_n),
   .wr_n     (wr_n),
   .port_q   (port_q),
   .wr_pulse (wr_pulse)
);

// File: tb/outport_latch_bench.sv
`timescale 1ns/1ps
module outport_latch_bench;
   import outport_pkg::*;

   localparam logic [15:0] P_ADDR = 16'h0007;
   localparam logic [15:0] M_ADDR = 16'h8007;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  data = '0;
   logic        iorq_n = 1'b1;
   logic        mreq_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [7:0]  p_q, m_q;
   logic        p_pls, m_pls;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] exp_p = 8'h00;
   logic [7:0] exp_m = 8'h00;

   always #2 clk = ~clk;

   outport_latch #(.MODE(DEC_PORT), .PORT_ADDR(P_ADDR)) u_outport_latch (
      .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .iorq_n(iorq_n),
      .mreq_n(mreq_n), .wr_n(wr_n), .port_q(p_q), .wr_pulse(p_pls));

   outport_latch #(.MODE(DEC_MEM), .PORT_ADDR(M_ADDR)) u_outport_latch_mem (
      .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .iorq_n(iorq_n),
      .mreq_n(mreq_n), .wr_n(wr_n), .port_q(m_q), .wr_pulse(m_pls));

   // {addr, data, iorq_n, mreq_n, wr_n}
   localparam int NV = 10;
   localparam logic [26:0] VEC [0:NV-1] = '{
      {16'h0007, 8'hA5, 1'b0, 1'b1, 1'b0},
      {16'h3407, 8'h5A, 1'b0, 1'b1, 1'b0},
      {16'h8007, 8'h3C, 1'b1, 1'b0, 1'b0},
      {16'h0007, 8'hFF, 1'b1, 1'b0, 1'b0},
      {16'h8007, 8'h11, 1'b0, 1'b1, 1'b0},
      {16'h0006, 8'h22, 1'b0, 1'b1, 1'b0},
      {16'h8007, 8'h33, 1'b1, 1'b0, 1'b1},
      {16'h0007, 8'h44, 1'b0, 1'b1, 1'b1},
      {16'h8107, 8'h55, 1'b1, 1'b0, 1'b0},
      {16'hFF07, 8'h00, 1'b0, 1'b1, 1'b0}
   };

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   // Runs one bus cycle with the strobes active for win cycles (at least 1).
   task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                            input logic io, input logic mr, input logic w,
                            input int win, input string rp, input string rm);
      logic hp, hm;
      hp = !io && !w && (a[7:0] == P_ADDR[7:0]);
      hm = !mr && !w && (a == M_ADDR);
      @(negedge clk);
      addr = a; data = d;
      iorq_n = io; mreq_n = mr; wr_n = w;
      for (int i = 0; i < win; i++) @(negedge clk);
      check("R7", "port copy in window", p_q, exp_p);
      check("R7", "mem copy in window", m_q, exp_m);
      iorq_n = 1'b1; mreq_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      if (hp) exp_p = d;
      if (hm) exp_m = d;
      check(rp, "port copy value", p_q, exp_p);
      check(rp, "port copy pulse", {7'd0, p_pls}, {7'd0, hp});
      check(rm, "mem copy value", m_q, exp_m);
      check(rm, "mem copy pulse", {7'd0, m_pls}, {7'd0, hm});
      @(negedge clk);
      check("R8", "port pulse low after", {7'd0, p_pls}, 8'h00);
      check("R8", "mem pulse low after", {7'd0, m_pls}, 8'h00);
      check("R9", "port copy holds", p_q, exp_p);
      check("R9", "mem copy holds", m_q, exp_m);
   endtask

   function automatic string tag_for(input logic hit, input logic own_n,
                                     input logic other_n, input logic w);
      if (hit)            return "R2/R3";
      if (w && !own_n)    return "R5";
      if (own_n && !other_n) return "R4";
      return "R6";
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual expired expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] a; logic [7:0] d; logic io, mr, w;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1", "port copy in reset", p_q, 8'h00);
      check("R1", "mem copy pulse in reset", {7'd0, m_pls}, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "port copy after reset", p_q, 8'h00);
      check("R1", "mem copy after reset", m_q, 8'h00);
      check("R1", "port pulse after reset", {7'd0, p_pls}, 8'h00);

      for (int v = 0; v < NV; v++) begin
         {a, d, io, mr, w} = VEC[v];
         bus_cycle(a, d, io, mr, w, 3,
            tag_for(!io && !w && (a[7:0] == P_ADDR[7:0]), io, mr, w),
            tag_for(!mr && !w && (a == M_ADDR), mr, io, w));
      end

      // R7: data changes inside the window, last sampled value wins
      @(negedge clk);
      addr = P_ADDR; data = 8'h10; iorq_n = 1'b0; wr_n = 1'b0;
      @(negedge clk); data = 8'h20;
      @(negedge clk); data = 8'h7E;
      @(negedge clk);
      check("R7", "no update while open", p_q, exp_p);
      iorq_n = 1'b1; wr_n = 1'b1; data = 8'h99;
      @(negedge clk);
      check("R7", "not yet updated one edge after close", p_q, exp_p);
      @(negedge clk);
      exp_p = 8'h7E;
      check("R7", "last in-window byte", p_q, exp_p);
      check("R8", "pulse with update", {7'd0, p_pls}, 8'h01);

      // R8: long window gives exactly one pulse
      begin
         int pulses = 0;
         @(negedge clk);
         addr = M_ADDR; data = 8'hC3; mreq_n = 1'b0; wr_n = 1'b0;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (m_pls) pulses++;
         end
         mreq_n = 1'b1; wr_n = 1'b1;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (m_pls) pulses++;
         end
         exp_m = 8'hC3;
         check("R8", "pulse count for long window", 8'(pulses), 8'd1);
         check("R3", "long window value", m_q, exp_m);
      end

      // R1: reset after writes clears the output
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1", "port copy cleared by reset", p_q, 8'h00);
      check("R1", "mem copy cleared by reset", m_q, 8'h00);
      rst_n = 1'b1; exp_p = 8'h00; exp_m = 8'h00;
      bus_cycle(16'h1207, 8'h6B, 1'b0, 1'b1, 1'b0, 1, "R2", "R4");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule